// File: doc/BRIEF.md
# Single-Lane Vector Move with Element Decode

This block copies one 16-bit lane of a 128-bit source vector into one lane of a destination vector. The other seven destination lanes pass through unchanged. The block takes four inputs: the source vector, the current contents of the destination vector, a 5-bit source selector and a 4-bit destination selector. It returns the updated destination vector one clock after a valid strobe.

The destination lane is simply the low three bits of the destination selector. The source lane is decoded with a deliberate merge quirk. Locate the highest set bit among bits 3..0 of the source selector. Source selector bits below that position keep their own value. From that position upward, the bits of the source lane index are taken from the destination selector instead. When bit 3 is set, the low three bits of the source selector select the source lane directly. When the selector is zero, the source lane equals the destination lane.

Bit 4 of the source selector has no defined meaning. When it is set, the block raises an error flag and returns the destination vector untouched.

Top module: `mvl_lane_move`

## Requirements
- R1: The destination lane is `dst_sel[2:0]`. Bit 3 of `dst_sel` has no effect on the result.
- R2: With `src_sel[4:3] = 2'b01`, the source lane is `src_sel[2:0]`.
- R3: With `src_sel[4:3] = 2'b00` and `src_sel[2:0]` nonzero, let m be the position of the highest set bit of `src_sel`. Each source lane index bit i below m equals `src_sel[i]`. Each index bit i at or above m equals `dst_sel[i]`.
- R4: With `src_sel = 0`, the source lane equals `dst_sel[2:0]`.
- R5: All output lanes other than the destination lane equal the corresponding lanes of `dst_vec`.
- R6: With `src_sel[4] = 1`, the next result has `out_err = 1` and `out_vec = dst_vec`. With `src_sel[4] = 0`, the next result has `out_err = 0`.
- R7: Lane 0 occupies bits 127:112. Lane k occupies bits 127-16k down to 112-16k.
- R8: A request with `in_valid = 1` at a rising edge yields `out_valid = 1` and its result right after that edge. Without `in_valid`, `out_valid` is 0 after the edge and `out_vec` and `out_err` keep their values.
- R9: A rising edge with `rst = 1` clears `out_valid`, `out_err` and `out_vec` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 128 | Vector supplying the moved lane |
| dst_vec | input | 128 | Current destination vector |
| src_sel | input | 5 | Source lane selector (merge-decoded) |
| dst_sel | input | 4 | Destination lane selector (low 3 bits used) |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_vec | output | 128 | Updated destination vector |
| out_err | output | 1 | Set when bit 4 of the source selector was set |

## Verification
Every result is due exactly one rising edge after its request. Both `out_valid` and the result appear together after that edge.

The bench drives each request on a falling edge and queues the expected vector and flag at that moment. A monitor on the next falling edge pops the queue and compares. Any `out_valid` pulse without a queued item counts as a failure.

The hold behaviour is checked two falling edges after the strobe drops, while the inputs are changed, to show that idle cycles leave the output untouched.

// File: rtl/mvl_pkg.sv
package mvl_pkg;

    localparam int DEF_LANE_W = 16;
    localparam int DEF_LANES  = 8;

    // How the source selector was interpreted for one request.
    typedef enum logic [1:0] {
        SEL_DIRECT   = 2'd0,
        SEL_MERGED   = 2'd1,
        SEL_DST_ONLY = 2'd2,
        SEL_INVALID  = 2'd3
    } sel_kind_e;

    function automatic logic is_fault(input sel_kind_e kind);
        return kind == SEL_INVALID;
    endfunction

endpackage

// File: rtl/mvl_sel_decode.sv
module mvl_sel_decode #(
    parameter int IDX_W = 3,
    parameter int SRC_W = IDX_W + 2
) (
    input  logic [SRC_W-1:0]  src_sel,
    input  logic [IDX_W-1:0]  dst_low,
    output logic [IDX_W-1:0]  src_idx,
    output logic [IDX_W-1:0]  dst_idx,
    output mvl_pkg::sel_kind_e kind
);
    // A source bit survives only if some set bit sits above it
    // (up to and including the direct-select bit).
    for (genvar i = 0; i < IDX_W; i++) begin : g_merge
        assign src_idx[i] = (|src_sel[IDX_W:i+1]) ? src_sel[i] : dst_low[i];
    end

    assign dst_idx = dst_low;

    always_comb begin
        if (src_sel[SRC_W-1])
            kind = mvl_pkg::SEL_INVALID;
        else if (src_sel[IDX_W])
            kind = mvl_pkg::SEL_DIRECT;
        else if (src_sel[IDX_W-1:0] == '0)
            kind = mvl_pkg::SEL_DST_ONLY;
        else
            kind = mvl_pkg::SEL_MERGED;
    end
endmodule

// File: rtl/mvl_lane_pick.sv
module mvl_lane_pick #(
    parameter int LANE_W = 16,
    parameter int LANES  = 8,
    parameter int IDX_W  = $clog2(LANES),
    parameter int VEC_W  = LANE_W * LANES
) (
    input  logic [VEC_W-1:0]  vec,
    input  logic [IDX_W-1:0]  idx,
    output logic [LANE_W-1:0] lane
);
    // Lane 0 is the most significant slice.
    always_comb begin
        lane = '0;
        for (int k = 0; k < LANES; k++) begin
            if (idx == IDX_W'(k))
                lane = vec[VEC_W-1-k*LANE_W -: LANE_W];
        end
    end
endmodule

// File: rtl/mvl_lane_place.sv
module mvl_lane_place #(
    parameter int LANE_W = 16,
    parameter int LANES  = 8,
    parameter int IDX_W  = $clog2(LANES),
    parameter int VEC_W  = LANE_W * LANES
) (
    input  logic [VEC_W-1:0]  base,
    input  logic [LANE_W-1:0] lane,
    input  logic [IDX_W-1:0]  idx,
    output logic [VEC_W-1:0]  vec
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HI = VEC_W - 1 - k * LANE_W;
        assign vec[HI -: LANE_W] = (idx == IDX_W'(k)) ? lane : base[HI -: LANE_W];
    end
endmodule

// File: rtl/mvl_lane_move.sv
module mvl_lane_move #(
    parameter int LANE_W = mvl_pkg::DEF_LANE_W,
    parameter int LANES  = mvl_pkg::DEF_LANES,
    parameter int IDX_W  = $clog2(LANES),
    parameter int VEC_W  = LANE_W * LANES,
    parameter int SRC_W  = IDX_W + 2,
    parameter int DST_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] dst_vec,
    input  logic [SRC_W-1:0] src_sel,
    input  logic [DST_W-1:0] dst_sel,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic             out_err
);
    logic [IDX_W-1:0]   src_idx;
    logic [IDX_W-1:0]   dst_idx;
    mvl_pkg::sel_kind_e kind;
    logic [LANE_W-1:0]  moved_lane;
    logic [VEC_W-1:0]   placed_vec;
    logic [VEC_W-1:0]   next_vec;
    logic               next_err;
    logic               unused_dst_top;

    // The top destination selector bit carries no meaning.
    assign unused_dst_top = dst_sel[DST_W-1];

    mvl_sel_decode #(
        .IDX_W (IDX_W),
        .SRC_W (SRC_W)
    ) u_decode (
        .src_sel (src_sel),
        .dst_low (dst_sel[IDX_W-1:0]),
        .src_idx (src_idx),
        .dst_idx (dst_idx),
        .kind    (kind)
    );

    mvl_lane_pick #(
        .LANE_W (LANE_W),
        .LANES  (LANES),
        .IDX_W  (IDX_W),
        .VEC_W  (VEC_W)
    ) u_pick (
        .vec  (src_vec),
        .idx  (src_idx),
        .lane (moved_lane)
    );

    mvl_lane_place #(
        .LANE_W (LANE_W),
        .LANES  (LANES),
        .IDX_W  (IDX_W),
        .VEC_W  (VEC_W)
    ) u_place (
        .base (dst_vec),
        .lane (moved_lane),
        .idx  (dst_idx),
        .vec  (placed_vec)
    );

    assign next_err = mvl_pkg::is_fault(kind);
    assign next_vec = next_err ? dst_vec : placed_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec <= next_vec;
                out_err <= next_err;
            end
        end
    end
endmodule

// File: rtl/mvl_lane_move_chk.sv
module mvl_lane_move_chk #(
    parameter int LANE_W = 16,
    parameter int LANES  = 8,
    parameter int IDX_W  = $clog2(LANES),
    parameter int VEC_W  = LANE_W * LANES,
    parameter int SRC_W  = IDX_W + 2,
    parameter int DST_W  = IDX_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [VEC_W-1:0] src_vec,
    input logic [VEC_W-1:0] dst_vec,
    input logic [SRC_W-1:0] src_sel,
    input logic [DST_W-1:0] dst_sel,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_vec,
    input logic             out_err
);
    function automatic logic [LANE_W-1:0] lane_of(input logic [VEC_W-1:0] v, input int i);
        return v[VEC_W-1-i*LANE_W -: LANE_W];
    endfunction

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_err && out_vec == '0)); // R9

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !$past(rst)) |=> (!out_valid && $stable(out_vec) && $stable(out_err))); // R8

    AST_FAULT_KEEPS_DEST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_sel[SRC_W-1]) |=> (out_err && out_vec == $past(dst_vec))); // R6

    AST_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !src_sel[SRC_W-1]) |=> !out_err); // R6

    AST_DIRECT_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_sel[SRC_W-1:IDX_W] == 2'b01) |=>
        (lane_of(out_vec, int'($past(dst_sel[IDX_W-1:0]))) ==
         lane_of($past(src_vec), int'($past(src_sel[IDX_W-1:0]))))); // R2

    AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_sel == '0) |=>
        (lane_of(out_vec, int'($past(dst_sel[IDX_W-1:0]))) ==
         lane_of($past(src_vec), int'($past(dst_sel[IDX_W-1:0]))))); // R4
endmodule

bind mvl_lane_move mvl_lane_move_chk #(
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .IDX_W  (IDX_W),
    .VEC_W  (VEC_W),
    .SRC_W  (SRC_W),
    .DST_W  (DST_W)
) u_chk (.*);

// File: tb/mvl_lane_move_bench.sv
`timescale 1ns/1ps
module mvl_lane_move_bench;
    localparam int LW = 16;
    localparam int NL = 8;
    localparam int VW = LW * NL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] dst_vec = '0;
    logic [4:0]    src_sel = '0;
    logic [3:0]    dst_sel = '0;
    logic          out_valid;
    logic [VW-1:0] out_vec;
    logic          out_err;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [VW-1:0] exp_vec_q[$];
    logic          exp_err_q[$];
    string         tag_q[$];
    logic [VW-1:0] last_vec;
    logic          last_err;

    always #2 clk = ~clk;

    mvl_lane_move u_mvl_lane_move (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_vec(src_vec), .dst_vec(dst_vec),
        .src_sel(src_sel), .dst_sel(dst_sel),
        .out_valid(out_valid), .out_vec(out_vec), .out_err(out_err)
    );

    function automatic logic [VW-1:0] mk_vec(input logic [15:0] seed);
        logic [VW-1:0] v;
        for (int i = 0; i < NL; i++)
            v[VW-1-i*LW -: LW] = seed ^ 16'(i * 16'h1357) ^ 16'(i << 12);
        return v;
    endfunction

    // Source lane from the highest-set-bit merge rule (R2, R3, R4).
    function automatic logic [2:0] ref_src_lane(input logic [4:0] ss, input logic [3:0] ds);
        int msb = -1;
        logic [2:0] r;
        for (int b = 0; b < 4; b++)
            if (ss[b]) msb = b;
        for (int b = 0; b < 3; b++)
            r[b] = (b < msb) ? ss[b] : ds[b];
        return r;
    endfunction

    task automatic check(input string tag, input logic ok, input logic [VW-1:0] act,
                         input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [VW-1:0] s, input logic [VW-1:0] d,
                         input logic [4:0] ss, input logic [3:0] ds);
        logic [VW-1:0] e;
        logic          er;
        string         t;
        logic [2:0]    sl;
        e  = d;
        er = ss[4];
        if (ss[4]) t = "R6 fault";
        else begin
            sl = ref_src_lane(ss, ds);
            e[VW-1-int'(ds[2:0])*LW -: LW] = s[VW-1-int'(sl)*LW -: LW];
            if (ss[3])          t = "R2 direct";
            else if (ss == 0)   t = "R4 zero";
            else                t = "R3 merge";
            if (ds[3])          t = {t, " R1 dst-msb"};
            t = {t, " R5 R7 R8"};
        end
        @(negedge clk);
        src_vec = s; dst_vec = d; src_sel = ss; dst_sel = ds; in_valid = 1'b1;
        exp_vec_q.push_back(e);
        exp_err_q.push_back(er);
        tag_q.push_back(t);
        last_vec = e;
        last_err = er;
    endtask

    // Monitor: results are due one edge after the request.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_vec_q.size() == 0) begin
                check("R8 unexpected out_valid", 1'b0, out_vec, '0);
            end else begin
                logic [VW-1:0] ev;
                logic          ee;
                string         tg;
                ev = exp_vec_q.pop_front();
                ee = exp_err_q.pop_front();
                tg = tag_q.pop_front();
                check({tg, " vec"}, out_vec === ev, out_vec, ev);
                check({tg, " err"}, out_err === ee, VW'(out_err), VW'(ee));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset out_valid", out_valid === 1'b0, VW'(out_valid), '0);
        check("R9 reset out_err", out_err === 1'b0, VW'(out_err), '0);
        check("R9 reset out_vec", out_vec === '0, out_vec, '0);
        rst = 1'b0;

        // R7: lane 0 is the top slice; move it to lane 7 (bits 15:0).
        drive(mk_vec(16'hA5C3), mk_vec(16'h0F0F), 5'b01000, 4'd7);
        // All selector values across several destinations.
        for (int ss = 0; ss < 16; ss++)
            for (int ds = 0; ds < 16; ds += 3)
                drive(mk_vec(16'(ss * 257 + ds)), mk_vec(16'(16'hBEEF ^ 16'(ds * 77))),
                      5'(ss), 4'(ds));
        // R1: top destination bit toggled with all else fixed.
        drive(mk_vec(16'h1111), mk_vec(16'h2222), 5'b00010, 4'b0101);
        drive(mk_vec(16'h1111), mk_vec(16'h2222), 5'b00010, 4'b1101);
        // R6: invalid selectors leave the destination unchanged.
        drive(mk_vec(16'h3333), mk_vec(16'h4444), 5'b10000, 4'd2);
        drive(mk_vec(16'h5555), mk_vec(16'h6666), 5'b11011, 4'd6);
        drive(mk_vec(16'h7777), mk_vec(16'h8888), 5'b11111, 4'd0);
        // Recovery after a fault clears the flag.
        drive(mk_vec(16'h9999), mk_vec(16'hAAAA), 5'b00101, 4'd3);

        @(negedge clk);
        in_valid = 1'b0;
        src_vec = mk_vec(16'hDEAD); dst_vec = mk_vec(16'hBEEF);
        src_sel = 5'b10000; dst_sel = 4'd1;
        @(negedge clk);
        @(negedge clk);
        check("R8 idle out_valid", out_valid === 1'b0, VW'(out_valid), '0);
        check("R8 idle hold vec", out_vec === last_vec, out_vec, last_vec);
        check("R8 idle hold err", out_err === last_err, VW'(out_err), VW'(last_err));
        check("R8 queue drained", exp_vec_q.size() == 0, VW'(exp_vec_q.size()), '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule